// File: doc/BRIEF.md
# Suspend-Mode Refresh Interval Timer

This block paces refresh requests for DRAM that is kept alive while the rest of the system is suspended. It runs entirely on a slow, free-running oscillator clock. A programmable 12-bit interval is loaded into a down-counter. Each time the counter runs out, the block raises a refresh request and holds it until the refresh sequencer returns an acknowledge.

Software reaches the block through one 16-bit control word that it can read and write at any time. The word holds the interval and an auto-adjust enable. When auto-adjust is on, an external calibration source presents oscillator counts measured over a fixed window. Each count is compared against a target, and the block nudges the interval up or down by a fixed step at the next reload.

Two resets are provided. A cold reset restores every default. A warm reset restarts the timing but keeps the programmed interval and the enable.

Top module: `susp_refresh_timer`

## Requirements
- R1: Reading returns bits 11:0 = interval and bit 12 = auto-adjust enable. Bits 15:13 always read 0, and a write to them has no effect.
- R2: Cold reset sets the control word to 0x0038 (interval 56, enable 0), loads the counter with 56 and drops the request.
- R3: Warm reset leaves the interval and the enable unchanged. It reloads the counter from the interval currently held, drops the request and discards any pending adjustment. A software write in the same cycle is still accepted.
- R4: With interval N (0 behaves as 1), the counter expires on the N-th rising edge after a load. At that edge it reloads from the interval held just before the edge, so requests repeat every N cycles.
- R5: A software write to the interval does not restart the counter. The new value is first used at the next reload.
- R6: An expiry sets the request. The request stays high until an edge that sees the acknowledge and has no new expiry. Expiries while the request is high are not queued.
- R7: While the enable is 0, hardware never changes the interval, and calibration samples are ignored and discard any pending adjustment.
- R8: While the enable is 1, a calibration sample above the target records an increase, one below records a decrease, and an equal one records no change. The newest sample replaces older ones. The change is applied only on an expiry edge, by ADJ_STEP, saturating at 1 and 4095. It is then cleared.
- R9: A software write on the same edge as a hardware update wins, and the pending adjustment is discarded.
- R10: Software reads and writes work at all times, including while auto-adjust is changing the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| cold_rst | input | 1 | Synchronous active-high full reset |
| warm_rst | input | 1 | Synchronous active-high reset that keeps the control word |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 16 | Control word write data |
| reg_rd_data | output | 16 | Control word read data |
| refresh_req | output | 1 | Suspend refresh request |
| refresh_ack | input | 1 | Acknowledge that clears the request |
| cal_valid | input | 1 | Calibration sample strobe |
| cal_count | input | CAL_W | Measured oscillator count |

## Verification
The bench builds the block with ADJ_STEP = 4 and CAL_TARGET = 100, and leaves the other parameters at their defaults. Because the step is large, a decrease from a small interval reaches the floor of 1 in one update. Together with a directed load of 4094, this brings both saturation edges within reach without waiting out long periods. Small programmed intervals make many expiries, overlapping acknowledges, warm resets and write-versus-update collisions occur within a few thousand cycles.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int REG_W   = 16;
    localparam int IVL_W   = 12;
    localparam int EN_BIT  = 12;
    localparam logic [IVL_W-1:0] IVL_MAX = {IVL_W{1'b1}};

    typedef struct packed {
        logic             en;
        logic [IVL_W-1:0] ivl;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]      = c.en;
        w[IVL_W-1:0]   = c.ivl;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [EN_BIT:0] w);
        ctrl_t c;
        c.en  = w[EN_BIT];
        c.ivl = w[IVL_W-1:0];
        return c;
    endfunction

    function automatic logic [IVL_W-1:0] apply_adj(input logic [IVL_W-1:0] ivl,
                                                   input adj_e dir,
                                                   input logic [IVL_W-1:0] step);
        logic [IVL_W:0] sum;
        sum = {1'b0, ivl} + {1'b0, step};
        case (dir)
            ADJ_UP:   return sum[IVL_W] ? IVL_MAX : sum[IVL_W-1:0];
            ADJ_DOWN: return (ivl > step) ? (ivl - step) : IVL_W'(1);
            default:  return ivl;
        endcase
    endfunction

endpackage

// File: rtl/srt_ctrl_reg.sv
module srt_ctrl_reg
    import srt_pkg::*;
#(
    parameter logic [IVL_W-1:0] DEFAULT_IVL = 12'h038
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             sw_wr,
    input  ctrl_t            sw_val,
    input  logic             hw_upd,
    input  logic [IVL_W-1:0] hw_ivl,
    output ctrl_t            ctrl_q
);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            ctrl_q.en  <= 1'b0;
            ctrl_q.ivl <= DEFAULT_IVL;
        end else if (sw_wr) begin
            ctrl_q <= sw_val;
        end else if (hw_upd) begin
            ctrl_q.ivl <= hw_ivl;
        end
    end

    AST_OFF_NO_HW_CHANGE: assert property (@(posedge clk) disable iff (cold_rst)
        (!ctrl_q.en && !sw_wr) |=> $stable(ctrl_q.ivl)); // R7

    AST_SW_WINS: assert property (@(posedge clk) disable iff (cold_rst)
        sw_wr |=> (ctrl_q == $past(sw_val))); // R9

endmodule

// File: rtl/srt_down_counter.sv
module srt_down_counter
    import srt_pkg::*;
#(
    parameter logic [IVL_W-1:0] DEFAULT_IVL = 12'h038
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             warm_rst,
    input  logic [IVL_W-1:0] reload_val,
    output logic             expire
);

    logic [IVL_W-1:0] cnt_q;

    assign expire = !cold_rst && !warm_rst && (cnt_q <= IVL_W'(1));

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            cnt_q <= DEFAULT_IVL;
        end else if (warm_rst || expire) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - IVL_W'(1);
        end
    end

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (expire && reload_val > IVL_W'(1)) |=> !expire); // R4

    AST_SHORT_REPEATS: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (expire && reload_val <= IVL_W'(1)) |=> (warm_rst || cold_rst || expire)); // R4

endmodule

// File: rtl/srt_req_hold.sv
module srt_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (set) begin
            req <= 1'b1;
        end else if (ack) begin
            req <= 1'b0;
        end
    end

    AST_REQ_SET: assert property (@(posedge clk) disable iff (rst)
        set |=> req); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req); // R6

    AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack && !set) |=> !req); // R6

endmodule

// File: rtl/srt_cal_track.sv
module srt_cal_track
    import srt_pkg::*;
#(
    parameter int CAL_W      = 16,
    parameter int CAL_TARGET = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cal_valid,
    input  logic [CAL_W-1:0] cal_count,
    input  logic             consume,
    output adj_e             pend
);

    localparam logic [CAL_W-1:0] TARGET = CAL_W'(CAL_TARGET);

    adj_e sample_dir;

    always_comb begin
        if (cal_count > TARGET) begin
            sample_dir = ADJ_UP;
        end else if (cal_count < TARGET) begin
            sample_dir = ADJ_DOWN;
        end else begin
            sample_dir = ADJ_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pend <= ADJ_NONE;
        end else if (cal_valid) begin
            pend <= sample_dir;
        end else if (consume) begin
            pend <= ADJ_NONE;
        end
    end

    AST_PEND_CLEAR_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pend == ADJ_NONE)); // R7

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (consume && !cal_valid) |=> (pend == ADJ_NONE)); // R8

endmodule

// File: rtl/susp_refresh_timer.sv
module susp_refresh_timer
    import srt_pkg::*;
#(
    parameter int               CAL_W       = 16,
    parameter int               CAL_TARGET  = 1000,
    parameter int               ADJ_STEP    = 1,
    parameter logic [IVL_W-1:0] DEFAULT_IVL = 12'h038
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             warm_rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             refresh_req,
    input  logic             refresh_ack,
    input  logic             cal_valid,
    input  logic [CAL_W-1:0] cal_count
);

    localparam logic [IVL_W-1:0] STEP = IVL_W'(ADJ_STEP);

    ctrl_t            ctrl;
    ctrl_t            sw_val;
    adj_e             pend;
    logic             expire;
    logic             hw_upd;
    logic [IVL_W-1:0] hw_ivl;

    assign sw_val = unpack_ctrl(reg_wr_data[EN_BIT:0]);
    assign hw_upd = expire && ctrl.en && (pend != ADJ_NONE);
    assign hw_ivl = apply_adj(ctrl.ivl, pend, STEP);

    srt_ctrl_reg #(
        .DEFAULT_IVL (DEFAULT_IVL)
    ) u_reg (
        .clk      (clk),
        .cold_rst (cold_rst),
        .sw_wr    (reg_wr_en),
        .sw_val   (sw_val),
        .hw_upd   (hw_upd),
        .hw_ivl   (hw_ivl),
        .ctrl_q   (ctrl)
    );

    srt_down_counter #(
        .DEFAULT_IVL (DEFAULT_IVL)
    ) u_cnt (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .warm_rst   (warm_rst),
        .reload_val (ctrl.ivl),
        .expire     (expire)
    );

    srt_req_hold u_req (
        .clk (clk),
        .rst (cold_rst || warm_rst),
        .set (expire),
        .ack (refresh_ack),
        .req (refresh_req)
    );

    srt_cal_track #(
        .CAL_W      (CAL_W),
        .CAL_TARGET (CAL_TARGET)
    ) u_cal (
        .clk       (clk),
        .rst       (cold_rst || warm_rst),
        .en        (ctrl.en),
        .cal_valid (cal_valid),
        .cal_count (cal_count),
        .consume   (expire || reg_wr_en),
        .pend      (pend)
    );

    assign reg_rd_data = pack_ctrl(ctrl);

    AST_IVL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (cold_rst)
        (!expire && !reg_wr_en) |=> $stable(reg_rd_data)); // R8

    AST_WARM_KEEPS: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && !reg_wr_en) |=> $stable(reg_rd_data)); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (cold_rst)
        reg_wr_en |=> (reg_rd_data[REG_W-1:EN_BIT+1] == '0)); // R1

    AST_WARM_DROPS_REQ: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> !refresh_req); // R3

endmodule

// File: tb/susp_refresh_timer_bench.sv
`timescale 1ns/1ps
module susp_refresh_timer_bench;

    localparam int CAL_W   = 16;
    localparam int TARGET  = 100;
    localparam int STEP    = 4;
    localparam int MAXIVL  = 4095;

    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic        refresh_req;
    logic        refresh_ack = 1'b0;
    logic        cal_valid = 1'b0;
    logic [CAL_W-1:0] cal_count = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string phase = "R2 cold reset";

    // bench reference state
    int m_ivl, m_en, m_cnt, m_req, m_pend; // pend: 0 none, 1 up, 2 down

    always #2.5 clk = ~clk;

    susp_refresh_timer #(
        .CAL_W      (CAL_W),
        .CAL_TARGET (TARGET),
        .ADJ_STEP   (STEP)
    ) u_susp_refresh_timer (
        .clk         (clk),
        .cold_rst    (cold_rst),
        .warm_rst    (warm_rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .refresh_req (refresh_req),
        .refresh_ack (refresh_ack),
        .cal_valid   (cal_valid),
        .cal_count   (cal_count)
    );

    function automatic int adjusted(int ivl, int dir);
        if (dir == 1) return (ivl + STEP > MAXIVL) ? MAXIVL : ivl + STEP;
        if (dir == 2) return (ivl > STEP) ? ivl - STEP : 1;
        return ivl;
    endfunction

    function automatic int classify(int cnt);
        if (cnt > TARGET) return 1;
        if (cnt < TARGET) return 2;
        return 0;
    endfunction

    task automatic model_step();
        int n_ivl, n_en, n_cnt, n_req, n_pend, ex;
        if (cold_rst) begin
            n_ivl = 56; n_en = 0; n_cnt = 56; n_req = 0; n_pend = 0;
        end else begin
            ex = (!warm_rst && m_cnt <= 1) ? 1 : 0;
            if (warm_rst || m_en == 0) n_pend = 0;
            else if (cal_valid) n_pend = classify(int'(cal_count));
            else if (ex == 1 || reg_wr_en) n_pend = 0;
            else n_pend = m_pend;
            n_ivl = m_ivl; n_en = m_en;
            if (reg_wr_en) begin
                n_ivl = int'(reg_wr_data[11:0]);
                n_en  = int'(reg_wr_data[12]);
            end else if (ex == 1 && m_en == 1 && m_pend != 0) begin
                n_ivl = adjusted(m_ivl, m_pend);
            end
            if (warm_rst || ex == 1) n_cnt = m_ivl;
            else n_cnt = m_cnt - 1;
            if (warm_rst) n_req = 0;
            else n_req = (ex == 1 || (m_req == 1 && !refresh_ack)) ? 1 : 0;
        end
        m_ivl = n_ivl; m_en = n_en; m_cnt = n_cnt; m_req = n_req; m_pend = n_pend;
    endtask

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("reg_rd_data", int'(reg_rd_data), (m_en << 12) | m_ivl);
        check("refresh_req", int'(refresh_req), m_req);
        cold_rst = 0; warm_rst = 0; reg_wr_en = 0; refresh_ack = 0; cal_valid = 0;
    endtask

    task automatic wr(int data);
        reg_wr_en = 1; reg_wr_data = 16'(data); tick();
    endtask

    task automatic cal(int cnt);
        cal_valid = 1; cal_count = CAL_W'(cnt); tick();
    endtask

    task automatic run(int n, bit ack_each);
        for (int i = 0; i < n; i++) begin
            refresh_ack = ack_each;
            tick();
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        phase = "R2 cold reset";
        cold_rst = 1; tick();
        cold_rst = 1; tick();
        phase = "R4 first period of 56";
        run(60, 1'b0);
        run(3, 1'b1);

        phase = "R1 reserved bits ignored";
        wr(16'hFFFF);
        wr(16'hE005);
        phase = "R5 write waits for reload";
        run(MAXIVL > 0 ? 30 : 0, 1'b0);
        phase = "R6 request held without ack";
        run(17, 1'b0);
        refresh_ack = 1; tick();
        run(12, 1'b1);

        phase = "R7 disabled ignores calibration";
        for (int i = 0; i < 30; i++) cal((i % 2 == 0) ? TARGET + 50 : TARGET - 50);

        phase = "R8 increase at reload";
        wr(16'h1006);
        cal(TARGET + 7);
        run(14, 1'b1);
        phase = "R8 newest sample and equal";
        cal(TARGET + 9); cal(TARGET - 9); run(8, 1'b0);
        cal(TARGET); run(12, 1'b1);
        phase = "R8 floor saturation";
        wr(16'h1002);
        cal(TARGET - 1); run(6, 1'b1);
        cal(0); run(4, 1'b1);
        phase = "R8 top saturation";
        wr(16'h1003);
        run(4, 1'b1);
        wr(16'h1FFE);
        cal(TARGET + 1);
        while (m_cnt > 1) tick();
        tick();

        phase = "R9 write wins over update";
        wr(16'h1005);
        run(6, 1'b1);
        cal(TARGET + 20);
        while (m_cnt > 1) tick();
        wr(16'h100A);
        run(25, 1'b1);

        phase = "R3 warm reset keeps word";
        wr(16'h1009);
        run(5, 1'b0);
        warm_rst = 1; tick();
        run(20, 1'b0);
        warm_rst = 1; reg_wr_en = 1; reg_wr_data = 16'h0004; tick();
        run(10, 1'b1);

        phase = "R10 random traffic";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                reg_wr_en = 1;
                reg_wr_data = 16'(($urandom_range(0, 7) << 13) | ($urandom_range(0, 1) << 12)
                                  | $urandom_range(0, 20));
            end
            refresh_ack = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0) begin
                cal_valid = 1;
                cal_count = CAL_W'(TARGET - 3 + $urandom_range(0, 6));
            end
            if ($urandom_range(0, 299) == 0) warm_rst = 1;
            if ($urandom_range(0, 1499) == 0) cold_rst = 1;
            tick();
        end

        done = 1;
        report();
    end

endmodule